// File: doc/BRIEF.md
# Base-Delta Register Block Expander

This block turns the compressed form of a wide vector register back into the block stream an execution unit expects. A compressed register is held as one base value, two stride values, a 2-bit pattern code and a subset-size field. After a start pulse, the expander emits the register as four 16-lane blocks of 32-bit lanes. Block 0 comes first, and one block follows on each successive cycle. The execution unit therefore sees the same timing whether or not the register was compressed.

Each burst carries a compressed flag. When the flag is clear, the block presented on the raw read-port input in each cycle of the burst is forwarded unchanged. When the flag is set, every lane is computed from the base and the strides. All pattern and stride fields are captured in the accepting cycle and hold for the whole burst. Bursts can follow each other with no idle cycle.

Top module: `bd_expand`

## Requirements
- R1: While reset is held, and after it, until the first accepted start, `out_valid` and `busy` are 0 and `out_blk` is all zeros. In any cycle where `out_valid` is 0, `out_blk` is all zeros. An asserted reset during a burst ends it.
- R2: A start sampled while `busy` is 0 is accepted. On the four clock edges starting with the accepting one, the output register loads blocks with `out_idx` 0, 1, 2, 3 in that order, with `out_valid` 1 throughout.
- R3: `busy` is 1 in the three cycles after an accepting edge that follow blocks 0, 1 and 2, and 0 once block 3 is shown. A start sampled while `busy` is 1 has no effect on the running burst.
- R4: A start in the cycle in which block 3 is on the output is accepted, so the next burst's block 0 follows block 3 with no gap.
- R5: Pattern code 2'b00 (flat): every lane equals the base.
- R6: Pattern code 2'b01 (single stride): global lane i (i = 16·block + j, lane j at bits [32j+31:32j]) equals base + i·delta1, modulo 2^32.
- R7: Pattern code 2'b10 (two-level stride): with S = 2^sub_log, lane i equals base + (i / S)·delta1 + (i mod S)·delta2, modulo 2^32. When S is 64 or larger, the delta1 term is zero.
- R8: Pattern code 2'b11 is reserved and expands like the flat pattern (every lane equals the base).
- R9: When the compressed flag of the burst is 0, block k of the output equals the `raw_blk` value presented in the k-th cycle of the burst (the accepting cycle is k = 0), bit for bit.
- R10: The compressed flag, pattern, sub_log, base and both deltas are sampled only in the accepting cycle. Changes to them during the burst do not alter its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a burst |
| cmp_in | input | 1 | Compressed flag of the register: 1 = expand, 0 = bypass |
| pat_in | input | 2 | Pattern code (00 flat, 01 single stride, 10 two-level, 11 reserved) |
| sub_log_in | input | 3 | log2 of the subset size for the two-level pattern |
| base_in | input | 32 | Base lane value |
| delta1_in | input | 32 | Stride between lanes, or between subsets in two-level mode |
| delta2_in | input | 32 | Stride between lanes within a subset (two-level mode) |
| raw_blk | input | 512 | Uncompressed block from the read port, for bypass |
| out_valid | output | 1 | Output block is valid |
| out_idx | output | 2 | Index of the block on the output |
| out_blk | output | 512 | Output block, 16 lanes of 32 bits |
| busy | output | 1 | Burst in progress; starts are not taken |

## Verification
The bench runs bursts back to back, and during every busy cycle it raises start again with inverted fields and an inverted compressed flag. A design that restarts while busy, or reads its fields after the accepting cycle, would then show a corrupted or restarted block sequence. Stride vectors that wrap past 2^32, a two-level subset of one lane and one of the full register, and negative deltas all target the lane arithmetic. A wrong shift, mask or carry would show up as wrong lanes in a late block. The bypass vector uses a different raw block in each cycle, so forwarding the wrong cycle's block, or expanding data that should pass through, gives a mismatch. Resetting in the middle of a burst checks that the output clears and that the next burst begins cleanly.

// File: rtl/bdx_pkg.sv
package bdx_pkg;

  localparam int LANE_W  = 32;
  localparam int LIDX_W  = 8;
  localparam int SUB_W   = 3;

  typedef enum logic [1:0] {
    PAT_FLAT = 2'b00,
    PAT_STEP = 2'b01,
    PAT_GRID = 2'b10,
    PAT_RSVD = 2'b11
  } pat_e;

  typedef struct packed {
    logic               cmp;
    pat_e               pat;
    logic [SUB_W-1:0]   sub_log;
    logic [LANE_W-1:0]  base;
    logic [LANE_W-1:0]  d1;
    logic [LANE_W-1:0]  d2;
  } fields_t;

  // Value of one lane given the pattern fields and the global lane index.
  function automatic logic [LANE_W-1:0] lane_val(
    input fields_t            f,
    input logic [LIDX_W-1:0]  lane
  );
    logic [LIDX_W-1:0] mask;
    logic [LIDX_W-1:0] grp;
    logic [LIDX_W-1:0] pos;
    logic [LANE_W-1:0] v;
    mask = LIDX_W'((9'd1 << f.sub_log) - 9'd1);
    grp  = lane >> f.sub_log;
    pos  = lane & mask;
    case (f.pat)
      PAT_STEP: v = f.base + f.d1 * LANE_W'(lane);
      PAT_GRID: v = f.base + f.d1 * LANE_W'(grp) + f.d2 * LANE_W'(pos);
      default:  v = f.base;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/bdx_seq.sv
module bdx_seq #(
  parameter int NUM_BLOCKS = 4,
  localparam int CNT_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             accept,
  output logic             step,
  output logic [CNT_W-1:0] idx,
  output logic             busy
);

  logic [CNT_W-1:0] cnt;
  logic             last;

  assign accept = start && !busy;
  assign step   = accept || busy;
  assign idx    = accept ? '0 : cnt;
  assign last   = (cnt == CNT_W'(NUM_BLOCKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (accept) begin
      cnt  <= CNT_W'(1);
      busy <= (NUM_BLOCKS > 1);
    end else if (busy) begin
      if (last) begin
        cnt  <= '0;
        busy <= 1'b0;
      end else begin
        cnt  <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/bdx_lanes.sv
module bdx_lanes
  import bdx_pkg::*;
#(
  parameter int LANES_PER_BLK = 16,
  parameter int IDX_W         = 2,
  localparam int BLK_W = LANES_PER_BLK * LANE_W
) (
  input  fields_t           f,
  input  logic [IDX_W-1:0]  blk_idx,
  output logic [BLK_W-1:0]  blk
);

  for (genvar j = 0; j < LANES_PER_BLK; j++) begin : g_lane
    logic [LIDX_W-1:0] gidx;
    assign gidx = LIDX_W'(blk_idx) * LIDX_W'(LANES_PER_BLK) + LIDX_W'(j);
    assign blk[j*LANE_W +: LANE_W] = lane_val(f, gidx);
  end

endmodule

// File: rtl/bdx_out.sv
module bdx_out #(
  parameter int BLK_W = 512,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [IDX_W-1:0] idx,
  input  logic             use_gen,
  input  logic [BLK_W-1:0] gen_blk,
  input  logic [BLK_W-1:0] raw_blk,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_idx,
  output logic [BLK_W-1:0] out_blk
);

  logic [BLK_W-1:0] pick;
  assign pick = use_gen ? gen_blk : raw_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_blk   <= '0;
    end else if (step) begin
      out_valid <= 1'b1;
      out_idx   <= idx;
      out_blk   <= pick;
    end else begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_blk   <= '0;
    end
  end

endmodule

// File: rtl/bd_expand.sv
module bd_expand
  import bdx_pkg::*;
#(
  parameter int NUM_LANES  = 64,
  parameter int NUM_BLOCKS = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  input  logic                                   cmp_in,
  input  logic [1:0]                             pat_in,
  input  logic [2:0]                             sub_log_in,
  input  logic [31:0]                            base_in,
  input  logic [31:0]                            delta1_in,
  input  logic [31:0]                            delta2_in,
  input  logic [(NUM_LANES/NUM_BLOCKS)*32-1:0]   raw_blk,
  output logic                                   out_valid,
  output logic [$clog2(NUM_BLOCKS)-1:0]          out_idx,
  output logic [(NUM_LANES/NUM_BLOCKS)*32-1:0]   out_blk,
  output logic                                   busy
);

  localparam int LPB   = NUM_LANES / NUM_BLOCKS;
  localparam int BLK_W = LPB * LANE_W;
  localparam int IDX_W = $clog2(NUM_BLOCKS);

  fields_t          in_f;
  fields_t          hold_f;
  fields_t          cur_f;
  logic             accept_w;
  logic             step_w;
  logic [IDX_W-1:0] idx_w;
  logic [BLK_W-1:0] gen_w;
  logic             cur_cmp_w;

  assign in_f.cmp     = cmp_in;
  assign in_f.pat     = pat_e'(pat_in);
  assign in_f.sub_log = sub_log_in;
  assign in_f.base    = base_in;
  assign in_f.d1      = delta1_in;
  assign in_f.d2      = delta2_in;

  bdx_seq #(.NUM_BLOCKS(NUM_BLOCKS)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .accept (accept_w),
    .step   (step_w),
    .idx    (idx_w),
    .busy   (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_f <= '0;
    else if (accept_w) hold_f <= in_f;
  end

  assign cur_f     = accept_w ? in_f : hold_f;
  assign cur_cmp_w = cur_f.cmp;

  bdx_lanes #(.LANES_PER_BLK(LPB), .IDX_W(IDX_W)) u_lanes (
    .f       (cur_f),
    .blk_idx (idx_w),
    .blk     (gen_w)
  );

  bdx_out #(.BLK_W(BLK_W), .IDX_W(IDX_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step_w),
    .idx       (idx_w),
    .use_gen   (cur_cmp_w),
    .gen_blk   (gen_w),
    .raw_blk   (raw_blk),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .out_blk   (out_blk)
  );

endmodule

// File: rtl/bdx_chk.sv
module bdx_chk #(
  parameter int BLK_W = 512,
  parameter int IDX_W = 2,
  parameter int NUM_BLOCKS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             step_w,
  input logic             cur_cmp_w,
  input logic [BLK_W-1:0] raw_blk,
  input logic             out_valid,
  input logic [IDX_W-1:0] out_idx,
  input logic [BLK_W-1:0] out_blk
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BLOCKS - 1);

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_blk == '0); // R1

  AST_FIRST_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (out_valid && out_idx == '0)); // R2

  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx != LAST) |=> (out_valid && out_idx == $past(out_idx) + IDX_W'(1))); // R2

  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (out_valid && out_idx != LAST)); // R3

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> out_idx != '0); // R3

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx == LAST && start) |=> (out_valid && out_idx == '0)); // R4

  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && !cur_cmp_w) |=> out_blk == $past(raw_blk)); // R9

endmodule

bind bd_expand bdx_chk #(
  .BLK_W(BLK_W), .IDX_W(IDX_W), .NUM_BLOCKS(NUM_BLOCKS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .step_w    (step_w),
  .cur_cmp_w (cur_cmp_w),
  .raw_blk   (raw_blk),
  .out_valid (out_valid),
  .out_idx   (out_idx),
  .out_blk   (out_blk)
);

// File: tb/bd_expand_bench.sv
module bd_expand_bench;

  localparam int LANES = 64;
  localparam int BLOCKS = 4;
  localparam int LPB = LANES / BLOCKS;
  localparam int BW = LPB * 32;
  localparam int NV = 9;

  // entry: {cmp, pat[1:0], sub_log[2:0], base, d1, d2}
  localparam logic [101:0] TBL [NV] = '{
    {1'b1, 2'b00, 3'd0, 32'hDEADBEEF, 32'h00000011, 32'h00000022},
    {1'b1, 2'b01, 3'd0, 32'h00001000, 32'h00000004, 32'h00000000},
    {1'b1, 2'b01, 3'd0, 32'hFFFFFFF0, 32'h00000100, 32'h00000009},
    {1'b1, 2'b10, 3'd3, 32'h00000100, 32'h00000040, 32'h00000001},
    {1'b1, 2'b10, 3'd0, 32'h00000007, 32'h00000003, 32'h00000777},
    {1'b1, 2'b10, 3'd6, 32'h00000020, 32'h00001000, 32'h00000005},
    {1'b1, 2'b11, 3'd2, 32'h00000055, 32'h00000009, 32'h00000003},
    {1'b0, 2'b01, 3'd0, 32'h12345678, 32'h00000001, 32'h00000001},
    {1'b1, 2'b10, 3'd4, 32'h40000000, 32'h80000000, 32'hFFFFFFFF}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic cmp_in;
  logic [1:0] pat_in;
  logic [2:0] sub_log_in;
  logic [31:0] base_in, delta1_in, delta2_in;
  logic [BW-1:0] raw_blk;
  logic out_valid;
  logic [1:0] out_idx;
  logic [BW-1:0] out_blk;
  logic busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bd_expand u_bd_expand (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in), .pat_in(pat_in),
    .sub_log_in(sub_log_in), .base_in(base_in), .delta1_in(delta1_in),
    .delta2_in(delta2_in), .raw_blk(raw_blk), .out_valid(out_valid),
    .out_idx(out_idx), .out_blk(out_blk), .busy(busy)
  );

  task automatic chk_blk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_val(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Lane value restated by integer division and remainder.
  function automatic logic [31:0] ref_lane(input logic [1:0] pat, input logic [2:0] sub,
      input logic [31:0] b, input logic [31:0] d1, input logic [31:0] d2, input int i);
    int s, q, r;
    s = 1 << sub;
    q = i / s;
    r = i % s;
    if (pat == 2'b01) return b + d1 * 32'(i);
    if (pat == 2'b10) return b + d1 * 32'(q) + d2 * 32'(r);
    return b;
  endfunction

  function automatic logic [BW-1:0] ref_blk(input logic [1:0] pat, input logic [2:0] sub,
      input logic [31:0] b, input logic [31:0] d1, input logic [31:0] d2, input int k);
    logic [BW-1:0] v;
    for (int j = 0; j < LPB; j++) v[j*32 +: 32] = ref_lane(pat, sub, b, d1, d2, k*LPB + j);
    return v;
  endfunction

  function automatic logic [BW-1:0] raw_of(input int k, input int tag);
    logic [BW-1:0] v;
    for (int j = 0; j < LPB; j++) v[j*32 +: 32] = 32'hA5000000 + 32'(tag << 8) + 32'(k*16 + j);
    return v;
  endfunction

  function automatic string req_of(input logic c, input logic [1:0] p);
    if (!c) return "R9";
    case (p)
      2'b00: return "R5";
      2'b01: return "R6";
      2'b10: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Called at a negedge; returns at the negedge where block 3 is checked.
  task automatic burst(input logic [101:0] e, input int tag, input bit b2b);
    logic c;
    logic [1:0] p;
    logic [2:0] s;
    logic [31:0] b, d1, d2;
    logic [BW-1:0] exp;
    {c, p, s, b, d1, d2} = e;
    start = 1'b1; cmp_in = c; pat_in = p; sub_log_in = s;
    base_in = b; delta1_in = d1; delta2_in = d2;
    raw_blk = raw_of(0, tag);
    for (int k = 0; k < BLOCKS; k++) begin
      @(negedge clk);
      exp = c ? ref_blk(p, s, b, d1, d2, k) : raw_of(k, tag);
      chk_blk($sformatf("%s R10 vec%0d blk%0d", req_of(c, p), tag, k), out_blk, exp);
      chk_val((k == 0 && b2b) ? "R4 first block valid/idx" : "R2 valid/idx",
              {out_valid, out_idx}, {1'b1, 2'(k)});
      chk_val("R3 busy", busy, (k < BLOCKS - 1) ? 1 : 0);
      if (k < BLOCKS - 1) begin
        // R3/R10: start while busy with changed fields must be ignored
        start = 1'b1; cmp_in = ~c; pat_in = ~p; sub_log_in = ~s;
        base_in = ~b; delta1_in = d1 ^ 32'h5A5A5A5A; delta2_in = ~d2;
        raw_blk = raw_of(k + 1, tag);
      end else begin
        start = 1'b0;
        raw_blk = '0;
      end
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cmp_in = 1'b0; pat_in = 2'b00; sub_log_in = 3'd0;
    base_in = '0; delta1_in = '0; delta2_in = '0; raw_blk = '0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk_val("R1 valid/busy in reset", {out_valid, busy}, 0);
    chk_blk("R1 blk in reset", out_blk, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_val("R1 valid/busy after reset", {out_valid, busy}, 0);
    chk_blk("R1 blk after reset", out_blk, '0);

    // table walk, bursts back to back
    for (int v = 0; v < NV; v++) burst(TBL[v], v, v > 0);

    @(negedge clk);
    chk_val("R1 idle valid/busy", {out_valid, busy}, 0);
    chk_blk("R1 idle blk zero", out_blk, '0);

    // reset in the middle of a burst
    start = 1'b1; cmp_in = 1'b1; pat_in = 2'b01; sub_log_in = 3'd0;
    base_in = 32'h1; delta1_in = 32'h1; delta2_in = 32'h0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_val("R1 mid-burst reset valid/busy", {out_valid, busy}, 0);
    chk_blk("R1 mid-burst reset blk", out_blk, '0);
    rst_n = 1'b1;
    @(negedge clk);
    burst(TBL[3], 3, 1'b0);
    @(negedge clk);
    chk_val("R1 final idle", {out_valid, busy}, 0);

    finish_run();
  end

endmodule